// File: doc/BRIEF.md
# Dual Reloadable Interval Timer

This block holds two 16-bit down-counters, A and B. Each one has a reload latch, a byte-wide control register and a seven-state sequencer. The sequencer places the start delay, the reload cycle and the stop-after-one-more-count behaviour on exact bus cycles. Everything advances only on system clock edges where the bus-cycle enable `cycEn` is high, and register writes are accepted on those edges as well.

Software writes a reload value as a low and a high byte, then writes the control register to start, stop or force-load the timer. Control writes are held for one bus cycle before the sequencer acts on them. The count-source selection in the written byte is the exception: it switches at once. When a running counter reaches its end it reloads from the latch and raises a one-cycle underflow pulse. A one-cycle interrupt request pulse follows on the next bus cycle. Timer B can count bus cycles or timer A underflows.

Register addresses (`addr`): 0 = A low byte, 1 = A high byte, 2 = B low byte, 3 = B high byte, 4 = A control, 5 = B control. Reads at 6 and 7 return 0.

Control bits:
- bit 0: run/start
- bit 3: one-shot
- bit 4: force-load strobe, never stored
- timer A, bit 5: 0 counts bus cycles, 1 counts nothing
- timer B, bits 6:5: 00 counts bus cycles, 10 counts A underflows, anything else counts nothing

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, both control registers read 0, `uflow` and `irq` are 0, and both latches hold 0x0001. Writing high byte 0x00 to a stopped timer right after reset therefore gives a count of 0x0001.
- R2: A low-byte write changes only the latch. A high-byte write updates the latch and, when control bit 0 is clear, also copies the whole latch into the counter on the same edge. While the timer runs, neither byte write changes the count.
- R3: Reads at addresses 0..3 return the live low and high counter bytes of A and B. Reads at 4 and 5 return the stored control byte, in which bit 4 always reads 0.
- R4: A control write becomes visible on read-back, and takes effect in the sequencer, one bus cycle after the write edge.
- R5: Starting a stopped timer without force-load gives one idle bus cycle after the control byte is applied. The first decrement lands on the third enabled edge after the write edge, and the count then falls by one per enabled edge.
- R6: When a running counter is at 1 (or 0) on an enabled edge, it reloads from the latch on that edge. `uflow` is high for the following cycle and `irq` for the cycle after that. In continuous mode the underflow period is latch+1 bus cycles.
- R7: In one-shot mode (bit 3) an underflow reloads the counter, clears bit 0, and the timer then holds its reloaded value.
- R8: A start with force-load applied to a running timer reloads from the latch on the second edge after the write, and counting resumes one edge later. A stop without force-load allows one more decrement after the control byte is applied, and the count then holds.
- R9: A start with force-load while the counter equals 1 takes the underflow path: the counter reloads, `uflow` pulses, and `irq` follows one cycle later.
- R10: Timer B with source 00 counts bus cycles and with source 10 decrements once per timer A underflow. Timer A with bit 5 set does not count.
- R11: While `cycEn` is low the counters, the sequencers and the interrupt outputs do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycEn | input | 1 | Bus-cycle enable; one high cycle per bus cycle |
| wrEn | input | 1 | Register write strobe, taken on edges where `cycEn` is high |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Combinational read data for `addr` |
| uflow | output | 2 | Underflow pulse per timer (bit 0 = A, bit 1 = B) |
| irq | output | 2 | Interrupt request pulse per timer, one bus cycle after `uflow` |

## Verification
The timers are driven with several patterns:
- A plain continuous start, which separates the idle start cycle, the reload cycle and the latch+1 period.
- A one-shot start, which shows that the start bit is cleared and the count holds afterwards.
- Force-load and stop writes issued while a timer is running; these expose the one-cycle control delay and the extra count before a stop.
- Force-load with the counter sitting at 1, which shows the underflow path being chosen instead of a plain reload.
- Timer B counting A underflows, and an idle stretch of `cycEn`, which show that B steps only on A reloads and that nothing moves while the enable is low.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LD_STOP,
    ST_LD_RUN,
    ST_LD_WAIT,
    ST_RUN,
    ST_RUN_STOP
  } seqState_t;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;

  localparam int BIT_START   = 0;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_FORCE   = 4;

  localparam logic [2:0] ADDR_CTRL_BASE = 3'd4;

endpackage

// File: rtl/dtmr_seq.sv
module dtmr_seq
  import dtmr_pkg::*;
#(
  parameter bit IS_B   = 1'b0,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              chainIn,
  input  logic              cntLe1,
  input  logic              cntEq1,
  input  logic              cntZero,
  output cntStrobe_t        strobe,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              underOut,
  output logic              flagQ,
  output logic              irqQ
);

  localparam logic [CTRL_W-1:0] FORCE_MASK = CTRL_W'(1) << BIT_FORCE;

  seqState_t         st, stN;
  logic [CTRL_W-1:0] ctrlN, pendVal, pendValN, applyVal;
  logic              pend, pendN;
  logic              srcCyc, srcChain, wrCyc, wrChain;
  logic              intr, runCount, ce, irqArm;

  generate
    if (IS_B) begin : gSrcB
      assign wrCyc   = (wrData[6:5] == 2'b00);
      assign wrChain = (wrData[6:5] == 2'b10);
    end else begin : gSrcA
      assign wrCyc   = ~wrData[5];
      assign wrChain = 1'b0;
    end
  endgenerate

  assign ce = srcCyc | (srcChain & chainIn);

  always_comb begin
    stN      = st;
    ctrlN    = ctrlQ;
    pendN    = pend;
    pendValN = pendVal;
    applyVal = pendVal;
    strobe   = '0;
    intr     = 1'b0;
    underOut = 1'b0;
    runCount = 1'b0;

    unique case (st)
      ST_WAIT:     stN = ST_RUN;
      ST_IDLE:     ;
      ST_LD_STOP:  begin stN = ST_IDLE; strobe.load = 1'b1; end
      ST_LD_RUN:   begin stN = ST_RUN;  strobe.load = 1'b1; end
      ST_LD_WAIT: begin
        stN = ST_WAIT;
        if (cntEq1) intr = 1'b1;
        else        strobe.load = 1'b1;
      end
      ST_RUN:      runCount = 1'b1;
      ST_RUN_STOP: begin stN = ST_IDLE; runCount = 1'b1; end
      default:     stN = ST_IDLE;
    endcase

    if (runCount && ce) begin
      if (cntLe1) begin
        underOut = 1'b1;
        if (st == ST_RUN) intr = 1'b1;
        else              strobe.dec = ~cntZero;
      end else begin
        strobe.dec = 1'b1;
      end
    end

    if (intr) begin
      strobe.load = 1'b1;
      underOut    = 1'b1;
      if (ctrlQ[BIT_ONESHOT]) begin
        ctrlN[BIT_START]    = 1'b0;
        pendValN[BIT_START] = 1'b0;
        stN = ST_LD_STOP;
      end else begin
        stN = ST_LD_RUN;
      end
    end

    if (pend) begin
      applyVal = pendValN;
      case (stN)
        ST_IDLE, ST_LD_STOP: begin
          if (applyVal[BIT_START])      stN = applyVal[BIT_FORCE] ? ST_LD_WAIT : ST_WAIT;
          else if (applyVal[BIT_FORCE]) stN = ST_LD_STOP;
        end
        ST_RUN: begin
          if (applyVal[BIT_START]) begin
            if (applyVal[BIT_FORCE]) stN = ST_LD_WAIT;
          end else begin
            stN = applyVal[BIT_FORCE] ? ST_LD_STOP : ST_RUN_STOP;
          end
        end
        ST_LD_RUN, ST_WAIT: begin
          if (applyVal[BIT_START]) begin
            if (applyVal[BIT_ONESHOT]) begin
              applyVal[BIT_START] = 1'b0;
              stN = ST_IDLE;
            end else if (applyVal[BIT_FORCE]) begin
              stN = ST_LD_WAIT;
            end
          end else begin
            stN = ST_IDLE;
          end
        end
        default: ;
      endcase
      ctrlN = applyVal & ~FORCE_MASK;
      pendN = 1'b0;
    end

    if (ctrlWr) begin
      pendN    = 1'b1;
      pendValN = wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      ctrlQ    <= '0;
      pend     <= 1'b0;
      pendVal  <= '0;
      srcCyc   <= 1'b1;
      srcChain <= 1'b0;
      irqArm   <= 1'b0;
      flagQ    <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      flagQ <= tick & intr;
      irqQ  <= tick & irqArm;
      if (tick) begin
        st      <= stN;
        ctrlQ   <= ctrlN;
        pend    <= pendN;
        pendVal <= pendValN;
        irqArm  <= intr;
        if (ctrlWr) begin
          srcCyc   <= wrCyc;
          srcChain <= wrChain;
        end
      end
    end
  end

endmodule

// File: rtl/dtmr_cnt.sv
module dtmr_cnt
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic             startBit,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] latchQ,
  output logic             cntLe1,
  output logic             cntEq1,
  output logic             cntZero
);

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] latchNew;

  always_comb begin
    latchNew = latchQ;
    if (wrLo)      latchNew = {latchQ[CNT_W-1:HALF], wrData};
    else if (wrHi) latchNew = {wrData, latchQ[HALF-1:0]};
  end

  assign cntZero = (cntQ == '0);
  assign cntEq1  = (cntQ == CNT_W'(1));
  assign cntLe1  = cntZero | cntEq1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '1;
      latchQ <= CNT_W'(1);
    end else if (tick) begin
      latchQ <= latchNew;
      if ((wrHi && !startBit) || strobe.load) cntQ <= latchNew;
      else if (strobe.dec)                    cntQ <= cntQ - CNT_W'(1);
    end
  end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycEn,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [1:0]        uflow,
  output logic [1:0]        irq
);

  logic [CNT_W-1:0]  cntAll   [2];
  logic [CNT_W-1:0]  latchAll [2];
  logic [BYTE_W-1:0] ctrlAll  [2];

  generate
    for (genvar i = 0; i < 2; i++) begin : gTmr
      cntStrobe_t strobe;
      logic underOut, chainIn, cntLe1, cntEq1, cntZero, flagQ, irqQ;

      if (i == 0) begin : gNoChain
        assign chainIn = 1'b0;
      end else begin : gChain
        assign chainIn = gTmr[0].underOut;
      end

      dtmr_seq #(.IS_B(i == 1), .CTRL_W(BYTE_W)) uSeq (
        .clk(clk), .rstN(rstN), .tick(cycEn),
        .ctrlWr(wrEn && addr == ADDR_CTRL_BASE + 3'(i)),
        .wrData(wrData), .chainIn(chainIn),
        .cntLe1(cntLe1), .cntEq1(cntEq1), .cntZero(cntZero),
        .strobe(strobe), .ctrlQ(ctrlAll[i]), .underOut(underOut),
        .flagQ(flagQ), .irqQ(irqQ)
      );

      dtmr_cnt #(.CNT_W(CNT_W)) uCnt (
        .clk(clk), .rstN(rstN), .tick(cycEn),
        .wrLo(wrEn && addr == 3'(2 * i)),
        .wrHi(wrEn && addr == 3'(2 * i + 1)),
        .wrData(wrData), .startBit(ctrlAll[i][BIT_START]), .strobe(strobe),
        .cntQ(cntAll[i]), .latchQ(latchAll[i]),
        .cntLe1(cntLe1), .cntEq1(cntEq1), .cntZero(cntZero)
      );

      assign uflow[i] = flagQ;
      assign irq[i]   = irqQ;
    end
  endgenerate

  always_comb begin
    case (addr)
      3'd0:    rdData = cntAll[0][BYTE_W-1:0];
      3'd1:    rdData = cntAll[0][CNT_W-1:BYTE_W];
      3'd2:    rdData = cntAll[1][BYTE_W-1:0];
      3'd3:    rdData = cntAll[1][CNT_W-1:BYTE_W];
      3'd4:    rdData = ctrlAll[0];
      3'd5:    rdData = ctrlAll[1];
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycEn,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic [1:0]       uflow,
  input logic [1:0]       irq,
  input logic [CNT_W-1:0] cntA,
  input logic [CNT_W-1:0] latchA,
  input logic [CNT_W-1:0] cntB,
  input logic [CNT_W-1:0] latchB,
  input logic [7:0]       ctrlA
);

  // R6: the cycle showing the underflow flag also shows the reloaded count
  assert_reload_on_flag_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    uflow[0] |-> cntA == latchA);

  assert_reload_on_flag_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    uflow[1] |-> cntB == latchB);

  // R6: the interrupt request follows the flag on the next bus cycle
  assert_irq_after_flag_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    uflow[0] && cycEn |=> irq[0]);

  assert_irq_after_flag_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    uflow[1] && cycEn |=> irq[1]);

  // R7: a one-shot underflow leaves the run bit cleared
  assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    uflow[0] && $past(ctrlA[3]) |-> !ctrlA[0]);

  // R2: a high-byte write to a stopped timer copies the latch into the count
  assert_hi_write_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && cycEn && addr == 3'd1 && !ctrlA[0] |=> cntA == latchA);

endmodule

bind dual_interval_timer dtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cycEn(cycEn), .wrEn(wrEn), .addr(addr),
  .uflow(uflow), .irq(irq),
  .cntA(cntAll[0]), .latchA(latchAll[0]),
  .cntB(cntAll[1]), .latchB(latchAll[1]),
  .ctrlA(ctrlAll[0])
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/100ps
module sim_dual_interval_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [1:0] uflow, irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .uflow(uflow), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #0.2;
    v = rdData;
  endtask

  task automatic cnt(input int t, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'(2 * t), lo);
    rd(3'(2 * t + 1), hi);
    v = {hi, lo};
  endtask

  task automatic chkCnt(input string req, input int t, input logic [15:0] exp);
    logic [15:0] v;
    cnt(t, v);
    chk(req, v, exp);
  endtask

  task automatic chkCtrl(input string req, input int t, input logic [7:0] exp);
    logic [7:0] v;
    rd(3'(4 + t), v);
    chk(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1;
    addr = a;
    wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cycEn = 1'b1;
    wrEn = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic tReset();
    doReset();
    chkCnt("R1 cntA", 0, 16'hFFFF);
    chkCnt("R1 cntB", 1, 16'hFFFF);
    chkCtrl("R1 ctrlA", 0, 8'h00);
    chkCtrl("R1 ctrlB", 1, 8'h00);
    chk("R1 uflow/irq", {12'h0, uflow, irq}, 16'h0);
    wr(3'd1, 8'h00);
    chkCnt("R1 latch reset value", 0, 16'h0001);
  endtask

  task automatic tLatch();
    doReset();
    wr(3'd0, 8'h34);
    chkCnt("R2 low byte leaves count", 0, 16'hFFFF);
    wr(3'd1, 8'h12);
    chkCnt("R2 high byte copies latch", 0, 16'h1234);
    wr(3'd2, 8'hCD);
    wr(3'd3, 8'hAB);
    chkCnt("R3 read B bytes", 1, 16'hABCD);
    chkCnt("R3 read A bytes", 0, 16'h1234);
  endtask

  task automatic tContinuous();
    doReset();
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    chkCtrl("R4 ctrl not yet applied", 0, 8'h00);
    step(1);
    chkCtrl("R4 ctrl applied", 0, 8'h01);
    step(1);
    chkCnt("R5 idle start cycle", 0, 16'h0005);
    step(1);
    chkCnt("R5 first decrement", 0, 16'h0004);
    step(3);
    chkCnt("R5 count at 1", 0, 16'h0001);
    chk("R6 no flag before end", {15'h0, uflow[0]}, 16'h0);
    step(1);
    chk("R6 flag on reload", {15'h0, uflow[0]}, 16'h1);
    chk("R6 irq not yet", {15'h0, irq[0]}, 16'h0);
    chkCnt("R6 reloaded", 0, 16'h0005);
    step(1);
    chk("R6 irq next cycle", {15'h0, irq[0]}, 16'h1);
    chk("R6 flag is a pulse", {15'h0, uflow[0]}, 16'h0);
    chkCnt("R6 reload cycle holds", 0, 16'h0005);
    step(1);
    chkCnt("R6 counting resumes", 0, 16'h0004);
    cycEn = 1'b0;
    step(3);
    chkCnt("R11 frozen without enable", 0, 16'h0004);
    chk("R11 irq idle", {15'h0, irq[0]}, 16'h0);
    cycEn = 1'b1;
    step(1);
    chkCnt("R11 resumes", 0, 16'h0003);
    step(3);
    chk("R6 period latch+1", {15'h0, uflow[0]}, 16'h1);
  endtask

  task automatic tOneShot();
    doReset();
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h09);
    step(5);
    chk("R7 one-shot flag", {15'h0, uflow[0]}, 16'h1);
    chkCtrl("R7 start cleared", 0, 8'h08);
    chkCnt("R7 reloaded", 0, 16'h0003);
    step(1);
    chk("R7 irq", {15'h0, irq[0]}, 16'h1);
    step(10);
    chkCnt("R7 holds after stop", 0, 16'h0003);
    chk("R7 no further flag", {15'h0, uflow[0]}, 16'h0);
  endtask

  task automatic tForceRun();
    doReset();
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    step(4);
    chkCnt("R5 running", 0, 16'h000E);
    wr(3'd0, 8'h40);
    chkCnt("R2 low write while running", 0, 16'h000D);
    wr(3'd4, 8'h11);
    chkCnt("R8 before apply", 0, 16'h000C);
    step(1);
    chkCnt("R8 apply cycle still counts", 0, 16'h000B);
    chkCtrl("R3 force bit reads 0", 0, 8'h01);
    step(1);
    chkCnt("R8 forced reload", 0, 16'h0040);
    step(1);
    chkCnt("R8 wait after reload", 0, 16'h0040);
    step(1);
    chkCnt("R8 counting after reload", 0, 16'h003F);
  endtask

  task automatic tStopRun();
    doReset();
    wr(3'd0, 8'h20);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    step(4);
    wr(3'd4, 8'h00);
    chkCnt("R8 stop write edge", 0, 16'h001D);
    step(1);
    chkCnt("R8 stop applied", 0, 16'h001C);
    chkCtrl("R4 stop visible", 0, 8'h00);
    step(1);
    chkCnt("R8 one more count", 0, 16'h001B);
    step(2);
    chkCnt("R8 held after stop", 0, 16'h001B);
    wr(3'd1, 8'h00);
    chkCnt("R2 high write when stopped", 0, 16'h0020);
  endtask

  task automatic tChain();
    doReset();
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h41);
    wr(3'd4, 8'h01);
    step(4);
    chk("R10 A underflow", {15'h0, uflow[0]}, 16'h1);
    chkCnt("R10 B stepped once", 1, 16'h0002);
    step(3);
    chkCnt("R10 B stepped twice", 1, 16'h0001);
    step(3);
    chk("R10 B underflow", {15'h0, uflow[1]}, 16'h1);
    chkCnt("R10 B reloaded", 1, 16'h0003);
    step(1);
    chk("R10 B irq", {15'h0, irq[1]}, 16'h1);
  endtask

  task automatic tSources();
    doReset();
    wr(3'd2, 8'h04);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h01);
    step(3);
    chkCnt("R10 B counts cycles", 1, 16'h0003);
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h21);
    step(8);
    chkCnt("R10 A source off", 0, 16'h0005);
    chk("R10 A no flag", {15'h0, uflow[0]}, 16'h0);
  endtask

  task automatic tForceAtOne();
    doReset();
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h05);
    chkCnt("R9 count stays 1", 0, 16'h0001);
    wr(3'd4, 8'h11);
    step(1);
    chkCnt("R9 apply cycle", 0, 16'h0001);
    step(1);
    chk("R9 underflow path flag", {15'h0, uflow[0]}, 16'h1);
    chkCnt("R9 reloaded", 0, 16'h0005);
    step(1);
    chk("R9 irq", {15'h0, irq[0]}, 16'h1);
    step(1);
    chkCnt("R9 counting", 0, 16'h0004);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tReset();
    tLatch();
    tContinuous();
    tOneShot();
    tForceRun();
    tStopRun();
    tChain();
    tSources();
    tForceAtOne();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule